// File: doc/BRIEF.md
# I2C EEPROM transaction sequencer

This controller sits above an I2C bit engine and turns one command into the full sequence of bus primitives needed for a register or EEPROM access. A command gives a 7-bit device address, a memory address of up to `ADDR_BYTES` bytes with a chosen address length, a transfer length and an operation (probe, write or read). The sequencer then asks the bit engine, one primitive at a time, for START, byte writes, byte reads and STOP. It checks every acknowledge the engine reports and sets status at the end.

Read transactions set the device's address pointer in a write phase. That phase is closed with a full STOP, and a fresh START then opens the read phase; no repeated start is used. For EEPROMs whose upper address bits occupy the device-select bits, an optional fold mode masks the address bits above the programmed length and ORs them into the device address. Write data is pulled one byte at a time through a take strobe. Read data leaves through a valid strobe.

Top module: `i2c_xact_seq`

## Requirements
- R1: Every transaction issues START (engine code 0) first. It then sends a byte write (engine code 2) of the device address in bits 7:1, with bit 0 = 0. The one exception is a read with address length 0, which sends bit 0 = 1.
- R2: After the device byte, the sequencer sends exactly `alen_i` address bytes, most significant byte first. Each byte is taken from `addr_i` bits [8k+7:8k].
- R3: A read with address length 0 skips the pointer-setting phase completely: START, device byte with bit 0 = 1, the data reads, then STOP.
- R4: A read with a nonzero address length closes the address phase with STOP (engine code 1). It then sends START and the device byte with bit 0 = 1, followed by `len_i` byte reads (engine code 3).
- R5: During reads, `eng_ack_o` is 0 (ACK) for every byte except the last, which gets 1 (NACK). Each byte read is presented once on `rd_data_o` with `rd_valid_o`.
- R6: With `ovf_en_i` = 1, the device address sent is `chip_i | (ovf_mask_i & bits [8*alen+6 : 8*alen] of addr_i)`. No bits are folded when `alen_i` = 4. With `ovf_en_i` = 0 the device address is sent unchanged.
- R7: A NACK on a device byte or an address byte ends the transaction with STOP, sets `addr_nack_o`, and sends no data bytes. A read that fails in its first phase never reaches its second.
- R8: On writes, all `len_i` data bytes are sent even after NACKs. `fail_cnt_o` counts the NACKed data bytes and is cleared when the next command is accepted.
- R9: Probe (op code 0, and the unused code 3) sends START, the device byte with bit 0 = 0, then STOP. It reports a missing device on `addr_nack_o`. Write is op code 1 and read is op code 2.
- R10: `busy_o` is high from the cycle after acceptance until completion. `done_o` is a one-cycle pulse while `busy_o` is low. A `start_i` while busy is ignored.
- R11: The sequencer keeps at most one engine request outstanding. It raises `eng_go_o` again only after `eng_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command strobe, accepted only when idle |
| op_i | input | 2 | 0 probe, 1 write, 2 read, 3 probe |
| chip_i | input | 7 | Device address |
| addr_i | input | 8*ADDR_BYTES | Memory address |
| alen_i | input | $clog2(ADDR_BYTES+1) | Number of address bytes |
| len_i | input | LEN_W | Number of data bytes |
| ovf_en_i | input | 1 | Fold high address bits into the device address |
| ovf_mask_i | input | 7 | Device-address bits that may receive folded bits |
| wr_data_i | input | 8 | Next write data byte |
| wr_take_o | output | 1 | Write data byte consumed this cycle |
| rd_valid_o | output | 1 | Read data byte valid |
| rd_data_o | output | 8 | Read data byte |
| eng_go_o | output | 1 | Request to the bit engine |
| eng_op_o | output | 2 | 0 START, 1 STOP, 2 byte write, 3 byte read |
| eng_byte_o | output | 8 | Byte to write |
| eng_ack_o | output | 1 | Acknowledge level to return after a read |
| eng_done_i | input | 1 | Bit engine finished the request |
| eng_nack_i | input | 1 | Acknowledge level seen after a byte write |
| eng_rdata_i | input | 8 | Byte read by the bit engine |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Transaction finished pulse |
| addr_nack_o | output | 1 | Device or address byte was not acknowledged |
| fail_cnt_o | output | LEN_W | Count of NACKed write data bytes |

## Verification
The embedded assertions watch the engine handshake on every cycle. A request is never raised twice without a completion between them, and none is raised while idle. The next request after a NACKed read or an address-phase NACK must be STOP. The data-failure count may only step by one, and the done pulse is a single idle cycle. The exact order of primitives and the byte values sent can only be shown by the bench's scenarios. This covers MSB-first addressing, the STOP/START split on reads, the skipped phase for zero address length, and the folded device address. The same holds for the delivered read data and the final status.

// File: rtl/i2c_xact_pkg.sv
package i2c_xact_pkg;

  localparam logic [1:0] OP_PROBE = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;

  localparam logic [1:0] BIT_START = 2'd0;
  localparam logic [1:0] BIT_STOP  = 2'd1;
  localparam logic [1:0] BIT_WRITE = 2'd2;
  localparam logic [1:0] BIT_READ  = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_CHIPW, S_ADDR, S_CHIPR, S_WDATA, S_RDATA, S_STOP
  } seq_state_e;

  // device address with high address bits optionally folded in
  function automatic logic [6:0] fold_chip(input logic [6:0] chip,
                                           input logic [31:0] addr,
                                           input logic [2:0] alen,
                                           input logic en,
                                           input logic [6:0] mask);
    logic [31:0] hi;
    hi = (alen >= 3'd4) ? 32'd0 : (addr >> {alen, 3'b000});
    return en ? (chip | (hi[6:0] & mask)) : chip;
  endfunction

  // byte idx of the address, 0 = least significant
  function automatic logic [7:0] addr_byte(input logic [31:0] addr,
                                           input logic [1:0] idx);
    logic [31:0] sh;
    sh = addr >> {idx, 3'b000};
    return sh[7:0];
  endfunction

endpackage

// File: rtl/i2c_xact_cmd.sv
module i2c_xact_cmd
  import i2c_xact_pkg::*;
#(
  parameter int AW   = 32,
  parameter int AL_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [1:0]      op_i,
  input  logic [6:0]      chip_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [AL_W-1:0] alen_i,
  input  logic            ovf_en_i,
  input  logic [6:0]      ovf_mask_i,
  output logic [1:0]      op_o,
  output logic [6:0]      chip_o,
  output logic [AW-1:0]   addr_o,
  output logic [AL_W-1:0] alen_o
);

  logic [6:0] chip_fold;
  assign chip_fold = fold_chip(chip_i, 32'(addr_i), 3'(alen_i), ovf_en_i, ovf_mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_o   <= OP_PROBE;
      chip_o <= '0;
      addr_o <= '0;
      alen_o <= '0;
    end else if (load_i) begin
      op_o   <= op_i;
      chip_o <= chip_fold;
      addr_o <= addr_i;
      alen_o <= alen_i;
    end
  end

endmodule

// File: rtl/i2c_xact_ctr.sv
module i2c_xact_ctr #(
  parameter int LEN_W = 8,
  parameter int AL_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [AL_W-1:0]  alen_i,
  input  logic             addr_step_i,
  input  logic             data_step_i,
  input  logic             fail_inc_i,
  output logic [AL_W-1:0]  aidx_o,
  output logic [LEN_W-1:0] fail_o,
  output logic             addr_last_o,
  output logic             rem_last_o,
  output logic             rem_zero_o
);

  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      aidx_o <= '0;
      fail_o <= '0;
    end else if (load_i) begin
      rem_q  <= len_i;
      aidx_o <= alen_i;
      fail_o <= '0;
    end else begin
      if (addr_step_i) aidx_o <= aidx_o - 1'b1;
      if (data_step_i) rem_q  <= rem_q - 1'b1;
      if (fail_inc_i)  fail_o <= fail_o + 1'b1;
    end
  end

  assign addr_last_o = (aidx_o == AL_W'(1));
  assign rem_last_o  = (rem_q == LEN_W'(1));
  assign rem_zero_o  = (rem_q == '0);

endmodule

// File: rtl/i2c_xact_txmux.sv
module i2c_xact_txmux
  import i2c_xact_pkg::*;
#(
  parameter int AW   = 32,
  parameter int AL_W = 3
) (
  input  seq_state_e      st_i,
  input  logic [6:0]      chip_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [AL_W-1:0] aidx_i,
  input  logic [7:0]      wr_data_i,
  output logic [7:0]      byte_o
);

  logic [AL_W-1:0] bidx;
  assign bidx = aidx_i - 1'b1;

  always_comb begin
    unique case (st_i)
      S_CHIPW: byte_o = {chip_i, 1'b0};
      S_CHIPR: byte_o = {chip_i, 1'b1};
      S_ADDR:  byte_o = addr_byte(32'(addr_i), 2'(bidx));
      S_WDATA: byte_o = wr_data_i;
      default: byte_o = 8'h00;
    endcase
  end

endmodule

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq
  import i2c_xact_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W      = 8,
  localparam int AW        = 8 * ADDR_BYTES,
  localparam int AL_W      = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [6:0]       chip_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [AL_W-1:0]  alen_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             ovf_en_i,
  input  logic [6:0]       ovf_mask_i,
  input  logic [7:0]       wr_data_i,
  output logic             wr_take_o,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o,
  output logic             eng_go_o,
  output logic [1:0]       eng_op_o,
  output logic [7:0]       eng_byte_o,
  output logic             eng_ack_o,
  input  logic             eng_done_i,
  input  logic             eng_nack_i,
  input  logic [7:0]       eng_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             addr_nack_o,
  output logic [LEN_W-1:0] fail_cnt_o
);

  seq_state_e      st_q;
  logic            wait_q, rd_phase_q;
  logic [1:0]      op_q;
  logic [6:0]      chip_q;
  logic [AW-1:0]   addr_q;
  logic [AL_W-1:0] alen_q, aidx;
  logic            addr_last, rem_last, rem_zero;

  // named internal events
  logic accept, step, addr_step, data_step, fail_inc, addr_nack_evt;
  assign accept        = (st_q == S_IDLE) && start_i;
  assign step          = wait_q && eng_done_i;
  assign addr_nack_evt = step && eng_nack_i &&
                         (st_q == S_CHIPW || st_q == S_ADDR || st_q == S_CHIPR);
  assign addr_step     = step && (st_q == S_ADDR) && !eng_nack_i;
  assign data_step     = step && (st_q == S_WDATA || st_q == S_RDATA);
  assign fail_inc      = step && (st_q == S_WDATA) && eng_nack_i;

  i2c_xact_cmd #(.AW(AW), .AL_W(AL_W)) u_cmd (
    .clk, .rst_n, .load_i(accept), .op_i, .chip_i, .addr_i, .alen_i,
    .ovf_en_i, .ovf_mask_i,
    .op_o(op_q), .chip_o(chip_q), .addr_o(addr_q), .alen_o(alen_q)
  );

  i2c_xact_ctr #(.LEN_W(LEN_W), .AL_W(AL_W)) u_ctr (
    .clk, .rst_n, .load_i(accept), .len_i, .alen_i,
    .addr_step_i(addr_step), .data_step_i(data_step), .fail_inc_i(fail_inc),
    .aidx_o(aidx), .fail_o(fail_cnt_o), .addr_last_o(addr_last),
    .rem_last_o(rem_last), .rem_zero_o(rem_zero)
  );

  i2c_xact_txmux #(.AW(AW), .AL_W(AL_W)) u_txmux (
    .st_i(st_q), .chip_i(chip_q), .addr_i(addr_q), .aidx_i(aidx),
    .wr_data_i, .byte_o(eng_byte_o)
  );

  assign eng_go_o  = (st_q != S_IDLE) && !wait_q;
  assign wr_take_o = eng_go_o && (st_q == S_WDATA);
  assign eng_ack_o = (st_q == S_RDATA) && rem_last;
  assign busy_o    = (st_q != S_IDLE);

  always_comb begin
    unique case (st_q)
      S_START: eng_op_o = BIT_START;
      S_STOP:  eng_op_o = BIT_STOP;
      S_RDATA: eng_op_o = BIT_READ;
      S_IDLE:  eng_op_o = BIT_START;
      default: eng_op_o = BIT_WRITE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      wait_q      <= 1'b0;
      rd_phase_q  <= 1'b0;
      done_o      <= 1'b0;
      addr_nack_o <= 1'b0;
      rd_valid_o  <= 1'b0;
      rd_data_o   <= '0;
    end else begin
      done_o     <= 1'b0;
      rd_valid_o <= 1'b0;
      if (accept) begin
        st_q        <= S_START;
        wait_q      <= 1'b0;
        addr_nack_o <= 1'b0;
        rd_phase_q  <= (op_i == OP_READ) && (alen_i == '0);
      end else if (eng_go_o) begin
        wait_q <= 1'b1;
      end else if (step) begin
        wait_q <= 1'b0;
        if (addr_nack_evt) addr_nack_o <= 1'b1;
        unique case (st_q)
          S_START: st_q <= rd_phase_q ? S_CHIPR : S_CHIPW;
          S_CHIPW: begin
            if (eng_nack_i) st_q <= S_STOP;
            else if (op_q != OP_WRITE && op_q != OP_READ) st_q <= S_STOP;
            else if (alen_q != '0) st_q <= S_ADDR;
            else st_q <= rem_zero ? S_STOP : S_WDATA;
          end
          S_ADDR: begin
            if (eng_nack_i) st_q <= S_STOP;
            else if (addr_last)
              st_q <= (op_q == OP_READ || rem_zero) ? S_STOP : S_WDATA;
          end
          S_CHIPR: begin
            if (eng_nack_i || rem_zero) st_q <= S_STOP;
            else st_q <= S_RDATA;
          end
          S_WDATA: if (rem_last) st_q <= S_STOP;
          S_RDATA: begin
            rd_valid_o <= 1'b1;
            rd_data_o  <= eng_rdata_i;
            if (rem_last) st_q <= S_STOP;
          end
          S_STOP: begin
            if (op_q == OP_READ && !rd_phase_q && !addr_nack_o) begin
              rd_phase_q <= 1'b1;
              st_q       <= S_START;
            end else begin
              st_q   <= S_IDLE;
              done_o <= 1'b1;
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  // ---------------- assertions ----------------
  logic rd_nack_q, abort_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_nack_q <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      if (eng_go_o) rd_nack_q <= (eng_op_o == BIT_READ) && eng_ack_o;
      if (addr_nack_evt) abort_q <= 1'b1;
      else if (eng_go_o) abort_q <= 1'b0;
    end
  end

  // R11
  go_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go_o |=> !eng_go_o);
  // R10
  go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go_o |-> busy_o);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o ##1 !done_o));
  // R5
  last_read_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_go_o && rd_nack_q) |-> (eng_op_o == BIT_STOP));
  // R7
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_go_o && abort_q) |-> (eng_op_o == BIT_STOP));
  // R8
  fail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_cnt_o != $past(fail_cnt_o)) |->
      ($past(accept) || fail_cnt_o == $past(fail_cnt_o) + 1'b1));
  // R8
  take_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take_o |-> (eng_go_o && eng_op_o == BIT_WRITE));

endmodule

// File: tb/i2c_xact_seq_tb.sv
module i2c_xact_seq_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [6:0]  chip_i = '0;
  logic [31:0] addr_i = '0;
  logic [2:0]  alen_i = '0;
  logic [7:0]  len_i = '0;
  logic        ovf_en_i = 1'b0;
  logic [6:0]  ovf_mask_i = '0;
  logic [7:0]  wr_data_i;
  logic        wr_take_o, rd_valid_o, eng_go_o, eng_ack_o;
  logic [7:0]  rd_data_o, eng_byte_o;
  logic [1:0]  eng_op_o;
  logic        eng_done_i, eng_nack_i;
  logic [7:0]  eng_rdata_i;
  logic        busy_o, done_o, addr_nack_o;
  logic [7:0]  fail_cnt_o;

  i2c_xact_seq #(.ADDR_BYTES(4), .LEN_W(8)) u_dut (
    .clk, .rst_n, .start_i, .op_i, .chip_i, .addr_i, .alen_i, .len_i,
    .ovf_en_i, .ovf_mask_i, .wr_data_i, .wr_take_o, .rd_valid_o, .rd_data_o,
    .eng_go_o, .eng_op_o, .eng_byte_o, .eng_ack_o, .eng_done_i, .eng_nack_i,
    .eng_rdata_i, .busy_o, .done_o, .addr_nack_o, .fail_cnt_o
  );

  int errors = 0;
  int checks = 0;

  // bit engine model and logs
  logic        clr = 1'b0;
  bit          nack_plan [0:31];
  logic [10:0] tlog [0:63];
  logic [10:0] texp [0:63];
  logic [7:0]  rbuf [0:31];
  int tn = 0, te = 0, wcnt = 0, rcnt = 0, rn = 0, widx = 0, ndone = 0, ovl = 0;
  logic pend = 1'b0;
  int   lat = 0;
  logic nack_nx = 1'b0;
  logic [7:0] rdat_nx = '0;

  assign wr_data_i = 8'h30 + 8'(widx);

  always @(posedge clk) begin
    eng_done_i <= 1'b0;
    if (clr) begin
      tn <= 0; wcnt <= 0; rcnt <= 0; rn <= 0; widx <= 0; ndone <= 0; ovl <= 0;
      pend <= 1'b0;
    end else begin
      if (done_o) ndone <= ndone + 1;
      if (rd_valid_o) begin rbuf[rn] <= rd_data_o; rn <= rn + 1; end
      if (wr_take_o) widx <= widx + 1;
      if (eng_go_o) begin
        if (pend) ovl <= ovl + 1;
        tlog[tn] <= {eng_op_o, (eng_op_o == 2'd2) ? eng_byte_o : 8'h00,
                     (eng_op_o == 2'd3) ? eng_ack_o : 1'b0};
        tn   <= tn + 1;
        pend <= 1'b1;
        lat  <= 2;
        nack_nx <= 1'b0;
        if (eng_op_o == 2'd2) begin nack_nx <= nack_plan[wcnt]; wcnt <= wcnt + 1; end
        if (eng_op_o == 2'd3) begin rdat_nx <= 8'hA0 + 8'(rcnt); rcnt <= rcnt + 1; end
      end else if (pend) begin
        if (lat == 0) begin
          eng_done_i  <= 1'b1;
          eng_nack_i  <= nack_nx;
          eng_rdata_i <= rdat_nx;
          pend        <= 1'b0;
        end else lat <= lat - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] bfold(input logic [6:0] c, input logic [31:0] a,
                                       input int al, input bit en, input logic [6:0] m);
    logic [31:0] s;
    if (!en) return c;
    s = (al >= 4) ? 32'd0 : (a >> (8 * al));
    return c | (s[6:0] & m);
  endfunction

  task automatic e_start(); texp[te] = {2'd0, 8'h00, 1'b0}; te++; endtask
  task automatic e_stop();  texp[te] = {2'd1, 8'h00, 1'b0}; te++; endtask
  task automatic e_wr(input logic [7:0] b); texp[te] = {2'd2, b, 1'b0}; te++; endtask
  task automatic e_rd(input bit a); texp[te] = {2'd3, 8'h00, a}; te++; endtask

  task automatic prep();
    @(negedge clk);
    clr = 1'b1;
    for (int i = 0; i < 32; i++) nack_plan[i] = 1'b0;
    te = 0;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic run(input logic [1:0] op, input logic [6:0] c, input logic [31:0] a,
                     input int al, input int ln, input bit en, input logic [6:0] m,
                     input bit poke_busy);
    op_i = op; chip_i = c; addr_i = a; alen_i = 3'(al); len_i = 8'(ln);
    ovf_en_i = en; ovf_mask_i = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R10 busy after accept", busy_o, 1);
    if (poke_busy) begin
      op_i = 2'd1; chip_i = 7'h7F; alen_i = 3'd2; len_i = 8'd4; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int i = 0; i < 3000; i++) begin
      if (done_o) break;
      @(negedge clk);
    end
    chk(done_o == 1'b1 && busy_o == 1'b0, "R10 done pulse while idle", {busy_o, done_o}, 1);
  endtask

  task automatic cmp_trace(input string tag);
    chk(tn == te, tag, tn, te);
    for (int k = 0; k < te && k < tn; k++)
      chk(tlog[k] == texp[k], tag, tlog[k], texp[k]);
  endtask

  task automatic t_probe_ack();
    prep();
    e_start(); e_wr({7'h50, 1'b0}); e_stop();
    run(2'd0, 7'h50, 32'h0, 0, 0, 0, 7'h0, 1'b1);
    cmp_trace("R9 R1 probe sequence");
    chk(addr_nack_o == 1'b0, "R9 probe acked", addr_nack_o, 0);
    repeat (20) @(negedge clk);
    chk(ndone == 1 && busy_o == 1'b0 && tn == 3, "R10 start while busy ignored", ndone, 1);
  endtask

  task automatic t_probe_nack();
    prep();
    nack_plan[0] = 1'b1;
    e_start(); e_wr({7'h5C, 1'b0}); e_stop();
    run(2'd3, 7'h5C, 32'h0, 2, 3, 0, 7'h0, 1'b0);
    cmp_trace("R9 probe code 3 sequence");
    chk(addr_nack_o == 1'b1, "R9 probe missing device", addr_nack_o, 1);
  endtask

  task automatic t_write_one_nack();
    prep();
    nack_plan[4] = 1'b1;
    e_start(); e_wr({7'h51, 1'b0}); e_wr(8'h12); e_wr(8'h34);
    e_wr(8'h30); e_wr(8'h31); e_wr(8'h32); e_stop();
    run(2'd1, 7'h51, 32'h1234, 2, 3, 0, 7'h0, 1'b0);
    cmp_trace("R2 write MSB-first sequence");
    chk(fail_cnt_o == 8'd1, "R8 one failed byte", fail_cnt_o, 1);
    chk(addr_nack_o == 1'b0, "R8 no address error", addr_nack_o, 0);
    chk(widx == 3, "R8 bytes taken", widx, 3);
  endtask

  task automatic t_write_all_nack();
    prep();
    nack_plan[2] = 1'b1; nack_plan[3] = 1'b1; nack_plan[4] = 1'b1;
    e_start(); e_wr({7'h51, 1'b0}); e_wr(8'h77);
    e_wr(8'h30); e_wr(8'h31); e_wr(8'h32); e_stop();
    run(2'd1, 7'h51, 32'h77, 1, 3, 0, 7'h0, 1'b0);
    cmp_trace("R8 write continues after nack");
    chk(fail_cnt_o == 8'd3, "R8 three failed bytes", fail_cnt_o, 3);
    prep();
    e_start(); e_wr({7'h51, 1'b0}); e_stop();
    run(2'd0, 7'h51, 32'h0, 0, 0, 0, 7'h0, 1'b0);
    chk(fail_cnt_o == 8'd0, "R8 count cleared by new command", fail_cnt_o, 0);
  endtask

  task automatic t_read_split();
    prep();
    e_start(); e_wr({7'h52, 1'b0}); e_wr(8'h10); e_stop();
    e_start(); e_wr({7'h52, 1'b1}); e_rd(1'b0); e_rd(1'b0); e_rd(1'b1); e_stop();
    run(2'd2, 7'h52, 32'h10, 1, 3, 0, 7'h0, 1'b0);
    cmp_trace("R4 R5 read with stop-start split");
    chk(rn == 3, "R5 read bytes delivered", rn, 3);
    for (int k = 0; k < 3 && k < rn; k++)
      chk(rbuf[k] == 8'hA0 + 8'(k), "R5 read data", rbuf[k], 8'hA0 + k);
  endtask

  task automatic t_read_noaddr();
    prep();
    e_start(); e_wr({7'h53, 1'b1}); e_rd(1'b0); e_rd(1'b1); e_stop();
    run(2'd2, 7'h53, 32'hFFFF, 0, 2, 0, 7'h0, 1'b0);
    cmp_trace("R3 read without address phase");
    chk(rn == 2, "R3 bytes delivered", rn, 2);
  endtask

  task automatic t_addr_nack();
    prep();
    nack_plan[1] = 1'b1;
    e_start(); e_wr({7'h54, 1'b0}); e_wr(8'hAB); e_stop();
    run(2'd1, 7'h54, 32'hABCD, 2, 2, 0, 7'h0, 1'b0);
    cmp_trace("R7 abort on address byte nack");
    chk(addr_nack_o == 1'b1, "R7 error flag", addr_nack_o, 1);
    chk(widx == 0 && fail_cnt_o == 0, "R7 no data sent", widx, 0);
    prep();
    nack_plan[0] = 1'b1;
    e_start(); e_wr({7'h55, 1'b0}); e_stop();
    run(2'd2, 7'h55, 32'h5, 1, 2, 0, 7'h0, 1'b0);
    cmp_trace("R7 read aborts in first phase");
    chk(rn == 0 && addr_nack_o == 1'b1, "R7 no read data", rn, 0);
  endtask

  task automatic t_fold();
    logic [6:0] c;
    prep();
    c = bfold(7'h50, 32'h305, 1, 1, 7'h07);
    e_start(); e_wr({c, 1'b0}); e_wr(8'h05); e_wr(8'h30); e_stop();
    run(2'd1, 7'h50, 32'h305, 1, 1, 1, 7'h07, 1'b0);
    cmp_trace("R6 folded device address");
    prep();
    e_start(); e_wr({7'h50, 1'b0}); e_wr(8'h05); e_wr(8'h30); e_stop();
    run(2'd1, 7'h50, 32'h305, 1, 1, 0, 7'h07, 1'b0);
    cmp_trace("R6 fold disabled");
    prep();
    c = bfold(7'h20, 32'h89ABCDEF, 4, 1, 7'h7F);
    e_start(); e_wr({c, 1'b0}); e_wr(8'h89); e_wr(8'hAB); e_wr(8'hCD); e_wr(8'hEF);
    e_stop(); e_start(); e_wr({c, 1'b1}); e_rd(1'b1); e_stop();
    run(2'd2, 7'h20, 32'h89ABCDEF, 4, 1, 1, 7'h7F, 1'b0);
    cmp_trace("R6 R2 four address bytes, nothing folded");
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && eng_go_o == 0, "R10 reset state", busy_o, 0);
    chk(addr_nack_o == 0 && fail_cnt_o == 0, "R8 reset status", fail_cnt_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_probe_ack();
    t_probe_nack();
    t_write_one_nack();
    t_write_all_nack();
    t_read_split();
    t_read_noaddr();
    t_addr_nack();
    t_fold();
    chk(ovl == 0, "R11 one request outstanding", ovl, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule